// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Byte Buffer

This block receives characters from an asynchronous serial line and hands them to a host through a small buffer. An external baud generator supplies a one-cycle sampling pulse. The receiver uses that pulse to validate a start bit and to collect the data bits, least significant bit first. It then collects an optional parity bit and a stop bit. Each finished character goes into a two-entry first-in first-out buffer. The host takes the oldest character from `rd_data` and pulses `rd_stb` to remove it.

Two flags describe how full the buffer is. `rdy` means at least one character is waiting. `full2` means both entries are in use. When the buffer is full, one further character is still accepted and held behind it. A later frame that arrives before the host reads anything replaces the held character and raises the overrun flag.

The parity, framing and overrun flags are sticky until the host pulses `err_clr`. Configuration inputs select the character length (`DATA_W` or `DATA_W-1` bits), whether a parity bit is present, and whether parity is even or odd.

Top module: `uart_rx_top`

## Requirements
- R1: After reset, `rdy`, `full2`, `par_err`, `frm_err` and `ovr_err` are all 0.
- R2: While `rx_en` is 0, line activity is ignored: no character enters the buffer and `rdy` stays 0.
- R3: A low line starts a frame only if the synchronised line is still low at the next `samp_tick`. Otherwise the receiver returns to idle and stores nothing.
- R4: Data bits are taken at `samp_tick` pulses, the first one into bit 0. When `cfg_short`=1, the character has `DATA_W-1` bits and `rd_data[DATA_W-1]` reads 0. When `cfg_short`=0, the character has `DATA_W` bits.
- R5: When `cfg_par_en`=1, the bit after the last data bit is parity. With `cfg_par_odd`=0, the data bits plus parity must hold an even number of ones; with 1, an odd number. A mismatch sets `par_err` when the character is stored. When `cfg_par_en`=0, no parity bit is expected and `par_err` is never set.
- R6: A stop bit sampled low sets `frm_err`. The character is still stored.
- R7: Reads return characters oldest first, and each `rd_stb` removes the entry shown on `rd_data`.
- R8: `rdy` is 1 when one or more entries are used. `full2` is 1 only when both are used. From full, the first read leaves `rdy` 1 and clears `full2`; a second read clears `rdy`.
- R9: `rd_stb` while the buffer is empty changes neither `rdy` nor `full2`.
- R10: A character completed while the buffer is full is held without error. In the same cycle that a read frees an entry, the held character enters the buffer, so `full2` stays 1.
- R11: A frame completed while a character is already held replaces that held character and sets `ovr_err`.
- R12: `err_clr` clears all three sticky error flags. An error event in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| samp_tick | input | 1 | One-cycle bit sampling pulse |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| cfg_short | input | 1 | 1 selects DATA_W-1 data bits |
| cfg_par_en | input | 1 | 1 expects a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_stb | input | 1 | Removes the oldest buffered character |
| err_clr | input | 1 | Clears sticky error flags |
| rd_data | output | DATA_W | Oldest buffered character |
| rdy | output | 1 | At least one character buffered |
| full2 | output | 1 | Both buffer entries used |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |

## Verification
The bench builds the block with `DATA_W`=8 and a two-stage synchroniser. With these values a full 8-bit character and the 7-bit mode, in which the top bit must read zero, can both be checked against hand-computed values. The bench generates its own sampling pulse every eight clocks, four clocks after each line change. That reaches a rejected start glitch, every parity setting, a low stop bit, and the full sequence of two buffered bytes plus a held byte, an overwritten held byte and the drain order that follows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int MAX_DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic short_len;
        logic par_en;
        logic par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic [MAX_DATA_W-1:0] data;
        logic                  par_bad;
        logic                  stop_bad;
    } rx_frame_t;

    // Mismatch when the ones count of data plus parity bit disagrees with the selected sense.
    function automatic logic par_mismatch(input logic [MAX_DATA_W-1:0] d,
                                          input logic pbit,
                                          input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      line,
    input  rx_cfg_t   cfg,
    output logic      frame_vld,
    output rx_frame_t frame
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    rx_state_e         state;
    rx_cfg_t           cfg_q;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic [CNT_W-1:0]  last_idx;

    assign last_idx = cfg_q.short_len ? LAST_SHORT : LAST_FULL;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_q     <= '0;
            cnt       <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cfg_q <= cfg;
                        end
                    end
                    ST_START: begin
                        if (tick) begin
                            if (!line) begin
                                state <= ST_DATA;
                                cnt   <= '0;
                                shreg <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (tick) begin
                            shreg[cnt] <= line;
                            if (cnt == last_idx)
                                state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                            else
                                cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (tick) begin
                            par_bit <= line;
                            state   <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        if (tick) begin
                            frame_vld      <= 1'b1;
                            frame.data     <= MAX_DATA_W'(shreg);
                            frame.par_bad  <= cfg_q.par_en &&
                                              par_mismatch(MAX_DATA_W'(shreg), par_bit, cfg_q.par_odd);
                            frame.stop_bad <= !line;
                            state          <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              full2,
    output logic              hold_v,
    output logic              ovr_hit
);
    localparam int DEPTH = 2;

    logic [DATA_W-1:0] ent_q [DEPTH];
    logic [DATA_W-1:0] ent_n [DEPTH];
    logic [1:0]        cnt_q, cnt_n;
    logic              hv_q, hv_n;
    logic [DATA_W-1:0] hd_q, hd_n;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_n[i] = ent_q[i];
        cnt_n   = cnt_q;
        hv_n    = hv_q;
        hd_n    = hd_q;
        ovr_hit = 1'b0;
        if (pop && cnt_q != 2'd0) begin
            ent_n[0] = ent_q[1];
            cnt_n    = cnt_n - 2'd1;
        end
        if (hv_n && cnt_n < 2'd2) begin
            ent_n[cnt_n[0]] = hd_n;
            cnt_n           = cnt_n + 2'd1;
            hv_n            = 1'b0;
        end
        if (push) begin
            if (cnt_n < 2'd2) begin
                ent_n[cnt_n[0]] = push_data;
                cnt_n           = cnt_n + 2'd1;
            end else if (!hv_n) begin
                hd_n = push_data;
                hv_n = 1'b1;
            end else begin
                hd_n    = push_data;
                ovr_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            cnt_q <= '0;
            hv_q  <= 1'b0;
            hd_q  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
            cnt_q <= cnt_n;
            hv_q  <= hv_n;
            hd_q  <= hd_n;
        end
    end

    assign rd_data = ent_q[0];
    assign rdy     = cnt_q != 2'd0;
    assign full2   = cnt_q == 2'd2;
    assign hold_v  = hv_q;
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              samp_tick,
    input  logic              rx_line,
    input  logic              cfg_short,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rd_stb,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              full2,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);
    logic      line_s;
    rx_cfg_t   cfg;
    logic      frame_vld;
    rx_frame_t frame;
    logic      hold_v;
    logic      ovr_hit;

    assign cfg = '{short_len: cfg_short, par_en: cfg_par_en, par_odd: cfg_par_odd};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(rx_line), .q(line_s)
    );

    uart_rx_framer #(.DATA_W(DATA_W)) u_framer (
        .clk(clk), .rst(rst), .en(rx_en), .tick(samp_tick), .line(line_s),
        .cfg(cfg), .frame_vld(frame_vld), .frame(frame)
    );

    uart_rx_buf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst(rst), .push(frame_vld), .push_data(frame.data[DATA_W-1:0]),
        .pop(rd_stb), .rd_data(rd_data), .rdy(rdy), .full2(full2),
        .hold_v(hold_v), .ovr_hit(ovr_hit)
    );

    // Sticky error flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            par_err <= 1'b0;
            frm_err <= 1'b0;
            ovr_err <= 1'b0;
        end else begin
            if (frame_vld && frame.par_bad)  par_err <= 1'b1;
            else if (err_clr)                par_err <= 1'b0;
            if (frame_vld && frame.stop_bad) frm_err <= 1'b1;
            else if (err_clr)                frm_err <= 1'b0;
            if (ovr_hit)                     ovr_err <= 1'b1;
            else if (err_clr)                ovr_err <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
    input logic clk,
    input logic rst,
    input logic rd_stb,
    input logic rdy,
    input logic full2,
    input logic ovr_err,
    input logic err_clr,
    input logic push,
    input logic hold_v
);
    a_r8_full_implies_ready: assert property (@(posedge clk) disable iff (rst)
        full2 |-> rdy);

    a_r10_hold_only_when_full: assert property (@(posedge clk) disable iff (rst)
        hold_v |-> full2);

    a_r9_empty_read_no_change: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !rdy && !push) |=> (!rdy && !full2));

    a_r11_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> $past(push && hold_v));

    a_r12_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !(push && hold_v)) |=> !ovr_err);

    a_r8_ready_needs_push: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(push));
endmodule

bind uart_rx_top uart_rx_chk u_chk (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rdy(rdy), .full2(full2),
    .ovr_err(ovr_err), .err_clr(err_clr), .push(frame_vld), .hold_v(hold_v)
);

// File: tb/tb_uart_rx_top.sv
module tb_uart_rx_top;
    localparam int DATA_W = 8;
    localparam int NVEC   = 9;
    // {stop_bad, bad_par, odd, par_en, short, data[7:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h7E},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h55},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hC3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0, samp_tick = 1'b0, rx_line = 1'b1;
    logic cfg_short = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic rd_stb = 1'b0, err_clr = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic rdy, full2, par_err, frm_err, ovr_err;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    uart_rx_top #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .samp_tick(samp_tick), .rx_line(rx_line),
        .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_stb(rd_stb), .err_clr(err_clr), .rd_data(rd_data), .rdy(rdy),
        .full2(full2), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic b);
        rx_line = b;
        repeat (4) @(negedge clk);
        samp_tick = 1'b1;
        @(negedge clk);
        samp_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic short_len, input logic pen,
                        input logic odd, input logic bad_par, input logic stop_bad);
        logic [7:0] m;
        m = short_len ? (d & 8'h7F) : d;
        cfg_short = short_len; cfg_par_en = pen; cfg_par_odd = odd;
        bit_time(1'b0);
        for (int i = 0; i < (short_len ? 7 : 8); i++) bit_time(d[i]);
        if (pen) bit_time((^m) ^ odd ^ bad_par);
        bit_time(!stop_bad);
        if (stop_bad) bit_time(1'b1);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_one;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_errs;
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdy", rdy, 0);
        check("R1 full2", full2, 0);
        check("R1 errs", {par_err, frm_err, ovr_err}, 0);

        // R2: disabled receiver ignores a frame
        send(8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 rdy while disabled", rdy, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // Table of frames
        for (int v = 0; v < NVEC; v++) begin
            logic [12:0] e;
            logic [7:0] exp_d;
            e = VEC[v];
            exp_d = e[8] ? (e[7:0] & 8'h7F) : e[7:0];
            send(e[7:0], e[8], e[9], e[10], e[11], e[12]);
            check("R8 rdy after one byte", rdy, 1);
            check("R8 full2 after one byte", full2, 0);
            check("R4 data", rd_data, exp_d);
            check("R5 parity flag", par_err, e[9] & e[11]);
            check("R6 framing flag", frm_err, e[12]);
            read_one();
            check("R7 read empties", rdy, 0);
            clear_errs();
            check("R12 cleared", {par_err, frm_err}, 0);
        end

        // R3: short low glitch is rejected
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        repeat (3) @(negedge clk);
        samp_tick = 1'b1; @(negedge clk); samp_tick = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 glitch stores nothing", rdy, 0);
        send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 recovers", rd_data, 8'h5A);
        read_one();

        // R9: read on empty
        read_one();
        check("R9 rdy", rdy, 0);
        check("R9 full2", full2, 0);

        // Fill, hold, overrun
        send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 full2 with two", full2, 1);
        check("R8 rdy with two", rdy, 1);
        send(8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10 held no overrun", ovr_err, 0);
        check("R10 still full", full2, 1);
        send(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 overrun set", ovr_err, 1);
        check("R7 oldest first", rd_data, 8'h11);
        read_one();
        check("R10 held moves in", full2, 1);
        check("R7 second", rd_data, 8'h22);
        read_one();
        check("R8 one left full2", full2, 0);
        check("R8 one left rdy", rdy, 1);
        check("R11 held replaced", rd_data, 8'h44);
        read_one();
        check("R8 drained", rdy, 0);
        clear_errs();
        check("R12 overrun cleared", ovr_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule